// File: doc/BRIEF.md
# Seconds Real-Time Clock with Two Alarm Channels

This block keeps wall-clock time as a 32-bit count of seconds. A slow timebase reaches it as single-cycle enable pulses in the bus clock domain. A prescaler turns a fixed number of these pulses into one second, and it also produces a faster periodic pulse.

Two alarm channels watch the counter. Each channel has a compare value and a small configuration register. The configuration register turns on the alarm interrupt, a periodic interrupt, or both. A matched alarm latches a flag in a shared status word. Software acknowledges the flag by writing a one to its bit.

Software works through a flat 32-bit register port with a combinational read path. Each channel drives its own level-sensitive interrupt line.

Top module: `sec_rtc`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the time counter, both alarm values, both configuration registers, all status flags and both interrupt lines are zero.
- R2: The register map uses byte offsets. 0x00 is status, 0x04 is channel-1 config, 0x08 is channel-2 config, 0x0C is time, 0x10 is channel-1 alarm and 0x14 is channel-2 alarm. Any other offset, unaligned offsets included, reads zero, and a write to it changes nothing.
- R3: The time counter increases by one after every TICKS_PER_SEC slow pulses.
- R4: A write to the time register loads the written value and restarts the prescaler. The next increment comes only after TICKS_PER_SEC further slow pulses.
- R5: An alarm flag sets on the increment that makes the time equal to that channel's alarm value. It sets whether or not the alarm interrupt is enabled, and it stays set until acknowledged. Status bit 0 is channel 1 and bit 1 is channel 2.
- R6: Writing the status register with bit n set clears the alarm flag and the periodic pending flag of channel n. Bits written as zero have no effect. If a match occurs in the same cycle as the clear, the flag stays set.
- R7: Configuration bits: bit 0 enables the alarm interrupt, bit 1 enables the periodic interrupt, and bit 2 selects a 1 Hz period when set or the fast period when clear.
- R8: When the periodic interrupt is enabled, each selected periodic pulse sets that channel's pending flag. Pending flags read at status bits 2 and 3. The interrupt line is (alarm flag AND alarm enable) OR pending flag.
- R9: A configuration write with bit 1 clear also clears that channel's pending flag. A write of zero leaves the interrupt line low from the next cycle.
- R10: The fast periodic pulse occurs FAST_PER_SEC times per second, aligned to the one-second boundary. Like the second, it restarts when the time register is written.
- R11: The time counter wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_en | input | 1 | One-cycle pulse per slow timebase period |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 2 | Interrupt lines, bit 0 for channel 1 and bit 1 for channel 2 |

## Verification
The assertions assume the following about the inputs:
- slow_en is already synchronous to clk and lasts exactly one cycle.
- TICKS_PER_SEC is a whole multiple of FAST_PER_SEC.
- An alarm value and a time write do not land in the very cycle whose match they would change.

The flag-clearing property is qualified by the absence of a same-cycle match, because a match is defined to win over the clear. The stimulus separates every slow pulse by idle cycles and issues register writes only between pulses. As a result, each write and each tick fall in different cycles, and the reference model compared on every clock never has to resolve a collision.

// File: rtl/sec_rtc_pkg.sv
// Package: shared offsets, field positions and types for the seconds RTC.
// Assumes word-aligned byte offsets that fit in 5 address bits.
package sec_rtc_pkg;
    localparam int DATA_W   = 32;
    localparam int NUM_CHAN = 2;

    localparam logic [4:0] OFF_STATUS = 5'h00;
    localparam logic [4:0] OFF_CFG_A  = 5'h04;
    localparam logic [4:0] OFF_CFG_B  = 5'h08;
    localparam logic [4:0] OFF_TIME   = 5'h0C;
    localparam logic [4:0] OFF_ALM_A  = 5'h10;
    localparam logic [4:0] OFF_ALM_B  = 5'h14;

    localparam int CFG_ALARM_EN = 0;
    localparam int CFG_PER_EN   = 1;
    localparam int CFG_PER_1HZ  = 2;

    typedef struct packed {
        logic per_1hz;
        logic per_en;
        logic alarm_en;
    } chan_cfg_t;
endpackage

// File: rtl/sec_rtc_prescaler.sv
// Module: divides slow_en pulses into a one-second tick and a faster periodic tick.
// Assumes TICKS_PER_SEC >= 2 and TICKS_PER_SEC a multiple of FAST_PER_SEC.
module sec_rtc_prescaler #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int FAST_PER_SEC  = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_en,
    input  logic restart,
    output logic sec_tick,
    output logic fast_tick
);
    localparam int FAST_DIV = TICKS_PER_SEC / FAST_PER_SEC;
    localparam int CNT_W    = $clog2(TICKS_PER_SEC);
    localparam int FST_W    = (FAST_DIV > 1) ? $clog2(FAST_DIV) : 1;
    localparam logic [CNT_W-1:0] SEC_LAST = CNT_W'(TICKS_PER_SEC - 1);
    localparam logic [FST_W-1:0] FST_LAST = FST_W'(FAST_DIV - 1);

    logic [CNT_W-1:0] sub_cnt;
    logic [FST_W-1:0] fast_cnt;

    assign sec_tick  = slow_en && !restart && (sub_cnt == SEC_LAST);
    assign fast_tick = slow_en && !restart && (fast_cnt == FST_LAST);

    // Count slow pulses within the second and within the fast period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            sub_cnt  <= '0;
            fast_cnt <= '0;
        end else if (slow_en) begin
            sub_cnt  <= (sub_cnt == SEC_LAST) ? '0 : sub_cnt + 1'b1;
            fast_cnt <= (fast_cnt == FST_LAST) ? '0 : fast_cnt + 1'b1;
        end
    end

    AST_SUB_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sub_cnt <= SEC_LAST); // R3
    AST_FAST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |-> fast_tick); // R10
endmodule

// File: rtl/sec_rtc_alarm_chan.sv
// Module: one alarm channel, holding the compare value, the config, the alarm flag,
// the periodic pending flag and the interrupt line.
// Assumes the write strobes come already decoded and time_now is the current count.
module sec_rtc_alarm_chan
    import sec_rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              val_we,
    input  logic              cfg_we,
    input  logic              ack,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] time_now,
    input  logic              sec_tick,
    input  logic              fast_tick,
    output logic [DATA_W-1:0] alarm_val,
    output chan_cfg_t         cfg,
    output logic              flag,
    output logic              pend,
    output logic              irq
);
    logic hit, per_sel, per_set, cfg_off;

    assign hit     = sec_tick && ((time_now + 32'd1) == alarm_val);
    assign per_sel = cfg.per_1hz ? sec_tick : fast_tick;
    assign per_set = cfg.per_en && per_sel;
    assign cfg_off = cfg_we && !wdata[CFG_PER_EN];
    assign irq     = (flag && cfg.alarm_en) || pend;

    // Hold the compare value and the configuration written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_val <= '0;
            cfg       <= '0;
        end else begin
            if (val_we) alarm_val <= wdata;
            if (cfg_we) cfg <= chan_cfg_t'(wdata[2:0]);
        end
    end

    // Latch the alarm match; a match wins over a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (ack) flag <= 1'b0;
    end

    // Latch the periodic pulse until acknowledged or disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)       pend <= 1'b0;
        else if (cfg_off) pend <= 1'b0;
        else if (per_set) pend <= 1'b1;
        else if (ack)     pend <= 1'b0;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ack) |=> flag); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit) |=> !flag); // R6
    AST_ZERO_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wdata[2:0] == 3'b000) |=> !irq); // R9
    AST_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> cfg.per_en); // R8
endmodule

// File: rtl/sec_rtc.sv
// Module: seconds RTC top, with the time counter, the register decode, the read mux
// and two alarm channels.
// Assumes slow_en is synchronous to clk and lasts one cycle per slow period.
module sec_rtc
    import sec_rtc_pkg::*;
#(
    parameter int ADDR_W        = 5,
    parameter int TICKS_PER_SEC = 32768,
    parameter int FAST_PER_SEC  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [1:0]        irq
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);
    localparam logic [ADDR_W-1:0] A_CFG_A  = ADDR_W'(OFF_CFG_A);
    localparam logic [ADDR_W-1:0] A_CFG_B  = ADDR_W'(OFF_CFG_B);
    localparam logic [ADDR_W-1:0] A_TIME   = ADDR_W'(OFF_TIME);
    localparam logic [ADDR_W-1:0] A_ALM_A  = ADDR_W'(OFF_ALM_A);
    localparam logic [ADDR_W-1:0] A_ALM_B  = ADDR_W'(OFF_ALM_B);

    logic [DATA_W-1:0]   time_cnt;
    logic                time_we, sec_tick, fast_tick;
    logic [DATA_W-1:0]   alm_val [NUM_CHAN];
    chan_cfg_t           ch_cfg  [NUM_CHAN];
    logic [NUM_CHAN-1:0] flag, pend;

    assign time_we = bus_we && (bus_addr == A_TIME);

    sec_rtc_prescaler #(
        .TICKS_PER_SEC(TICKS_PER_SEC),
        .FAST_PER_SEC (FAST_PER_SEC)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .slow_en  (slow_en),
        .restart  (time_we),
        .sec_tick (sec_tick),
        .fast_tick(fast_tick)
    );

    // Load the time on a write, otherwise advance it once per second.
    always_ff @(posedge clk) begin
        if (!rst_n)        time_cnt <= '0;
        else if (time_we)  time_cnt <= bus_wdata;
        else if (sec_tick) time_cnt <= time_cnt + 32'd1;
    end

    for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
        localparam logic [ADDR_W-1:0] A_VAL = A_ALM_A + ADDR_W'(4 * ch);
        localparam logic [ADDR_W-1:0] A_CFG = A_CFG_A + ADDR_W'(4 * ch);
        logic val_we, cfg_we, ack;

        assign val_we = bus_we && (bus_addr == A_VAL);
        assign cfg_we = bus_we && (bus_addr == A_CFG);
        assign ack    = bus_we && (bus_addr == A_STATUS) && bus_wdata[ch];

        sec_rtc_alarm_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .val_we   (val_we),
            .cfg_we   (cfg_we),
            .ack      (ack),
            .wdata    (bus_wdata),
            .time_now (time_cnt),
            .sec_tick (sec_tick),
            .fast_tick(fast_tick),
            .alarm_val(alm_val[ch]),
            .cfg      (ch_cfg[ch]),
            .flag     (flag[ch]),
            .pend     (pend[ch]),
            .irq      (irq[ch])
        );
    end

    // Return the addressed register, or zero for an unmapped offset.
    always_comb begin
        case (bus_addr)
            A_STATUS: bus_rdata = {28'd0, pend, flag};
            A_CFG_A:  bus_rdata = {29'd0, ch_cfg[0]};
            A_CFG_B:  bus_rdata = {29'd0, ch_cfg[1]};
            A_TIME:   bus_rdata = time_cnt;
            A_ALM_A:  bus_rdata = alm_val[0];
            A_ALM_B:  bus_rdata = alm_val[1];
            default:  bus_rdata = '0;
        endcase
    end

    AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sec_tick |=> (time_cnt == $past(time_cnt) + 32'd1)); // R3
    AST_TIME_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        time_we |=> (time_cnt == $past(bus_wdata))); // R4
    AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !time_we) |=> $stable(time_cnt)); // R4
endmodule

// File: tb/sec_rtc_bench.sv
// Bench: directed stimulus plus a behavioural reference model compared on every clock.
module sec_rtc_bench;
    localparam int TPS = 8;
    localparam int FPS = 4;
    localparam int FDIV = TPS / FPS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_en = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sec_rtc #(.ADDR_W(5), .TICKS_PER_SEC(TPS), .FAST_PER_SEC(FPS)) u_sec_rtc (
        .clk(clk), .rst_n(rst_n), .slow_en(slow_en), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Reference state.
    int          m_sub;
    logic [31:0] m_time;
    logic [31:0] m_alm [2];
    logic [2:0]  m_cfg [2];
    logic [1:0]  m_flag, m_pend;

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'h00:   return {28'd0, m_pend, m_flag};
            5'h04:   return {29'd0, m_cfg[0]};
            5'h08:   return {29'd0, m_cfg[1]};
            5'h0C:   return m_time;
            5'h10:   return m_alm[0];
            5'h14:   return m_alm[1];
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic [1:0] m_irq();
        logic [1:0] r;
        for (int n = 0; n < 2; n++) r[n] = (m_flag[n] && m_cfg[n][0]) || m_pend[n];
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    // Advance the model on each edge, then compare the outputs just after it.
    always @(posedge clk) begin : model
        logic twr, sec, fast, hit, psel, ack, coff;
        if (!rst_n) begin
            m_sub = 0; m_time = 0; m_flag = 0; m_pend = 0;
            for (int n = 0; n < 2; n++) begin m_alm[n] = 0; m_cfg[n] = 0; end
        end else begin
            twr  = bus_we && bus_addr == 5'h0C;
            sec  = slow_en && !twr && (m_sub == TPS - 1);
            fast = slow_en && !twr && (((m_sub + 1) % FDIV) == 0);
            for (int n = 0; n < 2; n++) begin
                hit  = sec && (m_time + 32'd1 == m_alm[n]);
                psel = m_cfg[n][2] ? sec : fast;
                ack  = bus_we && bus_addr == 5'h00 && bus_wdata[n];
                coff = bus_we && bus_addr == 5'(4 + 4 * n) && !bus_wdata[1];
                if (hit) m_flag[n] = 1'b1;
                else if (ack) m_flag[n] = 1'b0;
                if (coff) m_pend[n] = 1'b0;
                else if (m_cfg[n][1] && psel) m_pend[n] = 1'b1;
                else if (ack) m_pend[n] = 1'b0;
            end
            if (twr) m_sub = 0;
            else if (slow_en) m_sub = (m_sub == TPS - 1) ? 0 : m_sub + 1;
            if (twr) m_time = bus_wdata;
            else if (sec) m_time = m_time + 32'd1;
            if (bus_we) begin
                if (bus_addr == 5'h04) m_cfg[0] = bus_wdata[2:0];
                if (bus_addr == 5'h08) m_cfg[1] = bus_wdata[2:0];
                if (bus_addr == 5'h10) m_alm[0] = bus_wdata;
                if (bus_addr == 5'h14) m_alm[1] = bus_wdata;
            end
        end
        #2;
        chk("R8 irq vs model", {30'd0, irq}, {30'd0, m_irq()});
        chk("R2 readback vs model", bus_rdata, m_read(bus_addr));
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk); bus_we = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        @(negedge clk); bus_addr = a; #1;
        chk(req, bus_rdata, exp);
    endtask

    task automatic irq_chk(input string req, input int n, input logic exp);
        @(negedge clk); #1;
        chk(req, {31'd0, irq[n]}, {31'd0, exp});
    endtask

    task automatic pulses(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk); slow_en = 1'b1;
            @(negedge clk); slow_en = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 status", 5'h00, 0);
        rd_chk("R1 cfg1", 5'h04, 0);
        rd_chk("R1 cfg2", 5'h08, 0);
        rd_chk("R1 time", 5'h0C, 0);
        rd_chk("R1 alarm1", 5'h10, 0);
        rd_chk("R1 alarm2", 5'h14, 0);
        irq_chk("R1 irq1", 0, 1'b0);
        irq_chk("R1 irq2", 1, 1'b0);
        // R3 R4 counting and restart
        wr(5'h0C, 100); wr(5'h10, 103); wr(5'h04, 1);
        pulses(TPS - 1);
        rd_chk("R4 no step before full second", 5'h0C, 100);
        pulses(1);
        rd_chk("R3 one step per second", 5'h0C, 101);
        pulses(2 * TPS);
        rd_chk("R3 time at alarm", 5'h0C, 103);
        rd_chk("R5 alarm1 flag", 5'h00, 32'h1);
        irq_chk("R8 alarm1 irq", 0, 1'b1);
        // R6 write-one-to-clear
        wr(5'h00, 0);
        rd_chk("R6 zero write keeps flag", 5'h00, 32'h1);
        wr(5'h00, 1);
        rd_chk("R6 one clears flag", 5'h00, 0);
        irq_chk("R6 irq1 drops", 0, 1'b0);
        // R5 flag without enable
        wr(5'h0C, 48); wr(5'h14, 50);
        pulses(2 * TPS);
        rd_chk("R5 time reached", 5'h0C, 50);
        rd_chk("R5 alarm2 flag without enable", 5'h00, 32'h2);
        irq_chk("R5 irq2 stays low", 1, 1'b0);
        wr(5'h00, 2);
        rd_chk("R6 alarm2 cleared", 5'h00, 0);
        // R10 fast periodic on channel 2
        wr(5'h0C, 0); wr(5'h08, 2);
        pulses(FDIV - 1);
        irq_chk("R10 no fast pulse yet", 1, 1'b0);
        pulses(1);
        irq_chk("R10 fast pulse raises irq2", 1, 1'b1);
        rd_chk("R8 pending at bit 3", 5'h00, 32'h8);
        pulses(1);
        irq_chk("R8 pending held", 1, 1'b1);
        wr(5'h08, 0);
        irq_chk("R9 zero config drops irq2", 1, 1'b0);
        rd_chk("R9 pending cleared", 5'h00, 0);
        // R7 1 Hz selection on channel 1
        wr(5'h0C, 0); wr(5'h04, 6);
        pulses(TPS - 1);
        irq_chk("R7 1Hz not before second", 0, 1'b0);
        pulses(1);
        irq_chk("R7 1Hz at second", 0, 1'b1);
        rd_chk("R7 pending at bit 2", 5'h00, 32'h4);
        wr(5'h04, 0);
        irq_chk("R9 channel1 quiet", 0, 1'b0);
        // R11 wrap
        wr(5'h0C, 32'hFFFF_FFFF);
        pulses(TPS);
        rd_chk("R11 wrap to zero", 5'h0C, 0);
        // R2 unmapped offsets
        wr(5'h18, 32'h5);
        rd_chk("R2 unmapped 0x18", 5'h18, 0);
        rd_chk("R2 unmapped 0x1C", 5'h1C, 0);
        rd_chk("R2 unaligned 0x02", 5'h02, 0);
        rd_chk("R2 alarm1 untouched", 5'h10, 103);
        rd_chk("R2 alarm2 untouched", 5'h14, 50);
        rd_chk("R2 cfg1 untouched", 5'h04, 0);
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule